// File: doc/BRIEF.md
# Four-Channel Incremental Encoder Counter

This block keeps position counts for up to four incremental encoders. Each channel takes an A input, a B input and an index input, and keeps a 32-bit two's-complement count. A channel can decode A/B as a quadrature pair at four counts per cycle. It can also treat A as a pulse line and B as the direction line, counting on rising, falling or both edges of A. Counting can run always, stop, or follow the index level. The count can also be cleared by a constant hold, by the index level, or by index edges. Each channel has an optional glitch filter on its inputs.

Software reaches the block through a plain synchronous register port. Word address 0 is written as the control word. Each channel owns one byte of that word. The same address reads back the index levels. Word addresses 1 to 4 read the four counts. A read returns data one clock after the address is presented. The port has no back-pressure: a write is taken on every clock where the write strobe is high.

Top module: `qc_bank`

## Requirements
- R1: The control word at word address 0 gives channel n the byte [8n+7:8n]. Within the byte, [1:0] is the mode, [3:2] is the gating, [6:4] is the clear policy and bit 7 is the filter enable. A write applies from the next clock, and all control bits reset to 0.
- R2: Mode 0 decodes A/B as a quadrature pair. The sequence {A,B} = 00,10,11,01,00 adds one per step, and the reverse sequence subtracts one per step. A change of A and B in the same sample does not change the count.
- R3: In modes 1, 2 and 3, each rising edge, falling edge or either edge of A (in that order of mode) moves the count by one. The count goes up when B is 1 and down when B is 0.
- R4: Gating code 0 always counts and code 1 never counts. Code 2 counts only while index is 0, and code 3 counts only while index is 1.
- R5: Clear code 1 holds the count at zero. Code 2 clears while index is 0, and code 3 clears while index is 1.
- R6: Clear code 4 clears on an index rising edge, code 5 on a falling edge, and code 6 on either edge. Codes 0 and 7 never clear.
- R7: A clear condition wins over a count step in the same clock.
- R8: Every input passes through a two-flop synchronizer. With the filter enabled, a change is accepted only once it has held for 4 consecutive clocks, so a 3-clock pulse is dropped.
- R9: A read of word address 0 returns the filtered index level of channel n at bit 8n. Every other bit reads 0.
- R10: Word address 1+n returns the count of channel n. A count wraps modulo 2^32 and moves by at most one per clock. Writes to these addresses have no effect.
- R11: Read data is registered: it reflects the address presented one clock earlier. After reset, every read address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| enc_a | input | 4 | A input per channel (pulse line in direction modes) |
| enc_b | input | 4 | B input per channel (direction line in direction modes) |
| enc_idx | input | 4 | Index input per channel |

## Verification
A wrong decode, gating or clear state in a channel shows at that channel's count word on the next read after the offending input change. Counts only accumulate, so one lost or extra step stays visible for the rest of the run, until a clear hides it. A faulty synchronizer or filter shows as a count that moves on a short glitch, or as an index bit that reads wrong in the status word. Random control words and one-signal-at-a-time input steps are compared after each batch against a step model of the requirements. Directed sequences pin down literal values at wrap, at edge-triggered clears and at filter boundaries.

// File: rtl/qc_pkg.sv
package qc_pkg;

  localparam int SLICE_W = 8;

  typedef enum logic [1:0] {
    MODE_QUAD     = 2'd0,
    MODE_DIR_RISE = 2'd1,
    MODE_DIR_FALL = 2'd2,
    MODE_DIR_BOTH = 2'd3
  } qc_mode_e;

  typedef enum logic [1:0] {
    GATE_ALWAYS = 2'd0,
    GATE_NEVER  = 2'd1,
    GATE_IDX_LO = 2'd2,
    GATE_IDX_HI = 2'd3
  } qc_gate_e;

  typedef enum logic [2:0] {
    CLR_NONE     = 3'd0,
    CLR_HOLD     = 3'd1,
    CLR_IDX_LO   = 3'd2,
    CLR_IDX_HI   = 3'd3,
    CLR_IDX_RISE = 3'd4,
    CLR_IDX_FALL = 3'd5,
    CLR_IDX_ANY  = 3'd6,
    CLR_SPARE    = 3'd7
  } qc_clr_e;

  typedef struct packed {
    logic     filt;
    qc_clr_e  clr;
    qc_gate_e gate;
    qc_mode_e mode;
  } qc_ctrl_t;

endpackage

// File: rtl/qc_input_cond.sv
module qc_input_cond #(
  parameter int STABLE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic filt_en,
  output logic q
);
  localparam int CW = $clog2(STABLE + 1);
  localparam logic [CW-1:0] LAST = CW'(STABLE - 1);

  logic s1, s2;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= 1'b0;
      s2    <= 1'b0;
      q     <= 1'b0;
      run_q <= '0;
    end else begin
      s1 <= din;
      s2 <= s1;
      if (!filt_en) begin
        q     <= s2;
        run_q <= '0;
      end else if (s2 == q) begin
        run_q <= '0;
      end else if (run_q == LAST) begin
        q     <= s2;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  // R8
  filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_en && s2 == q) |=> $stable(q));

endmodule

// File: rtl/qc_channel.sv
module qc_channel
  import qc_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int STABLE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  qc_ctrl_t         ctl,
  input  logic             a_in,
  input  logic             b_in,
  input  logic             i_in,
  output logic [CNT_W-1:0] count,
  output logic             idx_lvl
);
  localparam int NSIG = 3;

  logic [NSIG-1:0] raw, cur, prv;
  assign raw = {i_in, b_in, a_in};

  for (genvar s = 0; s < NSIG; s++) begin : g_cond
    qc_input_cond #(.STABLE(STABLE)) i_cond (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (raw[s]),
      .filt_en(ctl.filt),
      .q      (cur[s])
    );
  end

  logic a_c, b_c, i_c, a_p, b_p, i_p;
  assign {i_c, b_c, a_c} = cur;
  assign {i_p, b_p, a_p} = prv;

  logic signed [1:0] step;
  logic pulse, gate_on, clr_hit;
  logic [CNT_W-1:0] count_q;

  always_comb begin
    step  = 2'sd0;
    pulse = 1'b0;
    if (ctl.mode == MODE_QUAD) begin
      unique case ({a_p, b_p, a_c, b_c})
        4'b0010, 4'b1011, 4'b1101, 4'b0100: step = 2'sd1;
        4'b0001, 4'b0111, 4'b1110, 4'b1000: step = -2'sd1;
        default:                            step = 2'sd0;
      endcase
    end else begin
      unique case (ctl.mode)
        MODE_DIR_RISE: pulse = a_c & ~a_p;
        MODE_DIR_FALL: pulse = ~a_c & a_p;
        default:       pulse = a_c ^ a_p;
      endcase
      if (pulse) step = b_c ? 2'sd1 : -2'sd1;
    end
  end

  always_comb begin
    unique case (ctl.gate)
      GATE_ALWAYS: gate_on = 1'b1;
      GATE_NEVER:  gate_on = 1'b0;
      GATE_IDX_LO: gate_on = ~i_c;
      default:     gate_on = i_c;
    endcase
  end

  always_comb begin
    unique case (ctl.clr)
      CLR_HOLD:     clr_hit = 1'b1;
      CLR_IDX_LO:   clr_hit = ~i_c;
      CLR_IDX_HI:   clr_hit = i_c;
      CLR_IDX_RISE: clr_hit = i_c & ~i_p;
      CLR_IDX_FALL: clr_hit = ~i_c & i_p;
      CLR_IDX_ANY:  clr_hit = i_c ^ i_p;
      default:      clr_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prv     <= '0;
      count_q <= '0;
    end else begin
      prv <= cur;
      if (clr_hit)
        count_q <= '0;
      else if (gate_on)
        count_q <= count_q + {{(CNT_W-2){step[1]}}, step};
    end
  end

  assign count   = count_q;
  assign idx_lvl = i_c;

  // R7
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> (count_q == '0));

  // R2
  quad_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.mode == MODE_QUAD && a_c != a_p && b_c != b_p && !clr_hit) |=> $stable(count_q));

  // R4
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.gate == GATE_NEVER && !clr_hit) |=> $stable(count_q));

  // R10
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_hit |=> (count_q == $past(count_q) || count_q == $past(count_q) + 1'b1 ||
                  count_q == $past(count_q) - 1'b1));

endmodule

// File: rtl/qc_bank.sv
module qc_bank
  import qc_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int DW     = 32,
  parameter int AW     = 3,
  parameter int STABLE = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [AW-1:0]  reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  input  logic [NCH-1:0] enc_a,
  input  logic [NCH-1:0] enc_b,
  input  logic [NCH-1:0] enc_idx
);
  localparam int CTRL_W = NCH * SLICE_W;
  localparam logic [AW-1:0] CTRL_ADDR = '0;

  logic [CTRL_W-1:0] ctrl_q;
  logic [DW-1:0]     cnt_arr [NCH];
  logic [NCH-1:0]    idx_lvl;
  logic [DW-1:0]     status_w, rd_mux;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctrl_q <= '0;
    else if (reg_wr && reg_addr == CTRL_ADDR)
      ctrl_q <= reg_wdata[CTRL_W-1:0];
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    qc_channel #(.CNT_W(DW), .STABLE(STABLE)) i_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctl    (qc_ctrl_t'(ctrl_q[n*SLICE_W +: SLICE_W])),
      .a_in   (enc_a[n]),
      .b_in   (enc_b[n]),
      .i_in   (enc_idx[n]),
      .count  (cnt_arr[n]),
      .idx_lvl(idx_lvl[n])
    );
  end

  always_comb begin
    status_w = '0;
    for (int n = 0; n < NCH; n++) status_w[n*SLICE_W] = idx_lvl[n];
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr == CTRL_ADDR) rd_mux = status_w;
    for (int n = 0; n < NCH; n++)
      if (reg_addr == AW'(n + 1)) rd_mux = cnt_arr[n];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= rd_mux;
  end

  // R11
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == CTRL_ADDR) |=> (reg_rdata == $past(status_w)));

endmodule

// File: tb/test_qc_bank.sv
`timescale 1ns/1ps
module test_qc_bank;
  localparam int NCH = 4;
  localparam int HOLD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0] pa = '0, pb = '0, pi = '0;

  int checks = 0, errors = 0;
  logic [7:0]  ctl [NCH];
  logic [31:0] exp_cnt [NCH];

  always #2.5 clk = ~clk;

  qc_bank i_qc_bank (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .enc_a(pa), .enc_b(pb), .enc_idx(pi)
  );

  function automatic int gray_pos(logic a, logic b);
    if (a) return b ? 2 : 1;
    return b ? 3 : 0;
  endfunction

  function automatic int step_of(logic [1:0] m, logic oa, logic ob, logic a, logic b);
    int d;
    logic e;
    if (m == 2'd0) begin
      d = (gray_pos(a, b) - gray_pos(oa, ob)) & 3;
      return (d == 1) ? 1 : (d == 3) ? -1 : 0;
    end
    e = (m == 2'd1) ? (a && !oa) : (m == 2'd2) ? (!a && oa) : (a != oa);
    return e ? (b ? 1 : -1) : 0;
  endfunction

  function automatic logic clr_of(logic [2:0] c, logic oi, logic i);
    case (c)
      3'd1: return 1'b1;
      3'd2: return !i;
      3'd3: return i;
      3'd4: return i && !oi;
      3'd5: return !i && oi;
      3'd6: return i != oi;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic gate_of(logic [1:0] g, logic i);
    case (g)
      2'd0: return 1'b1;
      2'd1: return 1'b0;
      2'd2: return !i;
      default: return i;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic set_pins(logic [3:0] na, logic [3:0] nb, logic [3:0] ni);
    for (int c = 0; c < NCH; c++) begin
      if (clr_of(ctl[c][6:4], pi[c], ni[c]))
        exp_cnt[c] = 32'd0;
      else if (gate_of(ctl[c][3:2], ni[c]))
        exp_cnt[c] = exp_cnt[c] + 32'(step_of(ctl[c][1:0], pa[c], pb[c], na[c], nb[c]));
    end
    @(negedge clk);
    pa = na; pb = nb; pi = ni;
    repeat (HOLD) @(posedge clk);
  endtask

  task automatic tog(int c, int s);
    logic [3:0] na, nb, ni;
    na = pa; nb = pb; ni = pi;
    if (s == 0) na[c] = ~na[c];
    else if (s == 1) nb[c] = ~nb[c];
    else ni[c] = ~ni[c];
    set_pins(na, nb, ni);
  endtask

  task automatic wr(logic [2:0] addr, logic [31:0] data);
    if (addr == 3'd0)
      for (int c = 0; c < NCH; c++) begin
        ctl[c] = data[8*c +: 8];
        if (clr_of(ctl[c][6:4], pi[c], pi[c])) exp_cnt[c] = 32'd0;
      end
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = addr; reg_wdata = data;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  task automatic set_slice(int c, logic [7:0] v);
    logic [31:0] w;
    for (int k = 0; k < NCH; k++) w[8*k +: 8] = ctl[k];
    w[8*c +: 8] = v;
    wr(3'd0, w);
  endtask

  task automatic rd(logic [2:0] addr, output logic [31:0] data);
    @(negedge clk);
    reg_addr = addr;
    @(posedge clk);
    @(negedge clk);
    data = reg_rdata;
  endtask

  task automatic cnt_is(string tag, int c, logic [31:0] lit);
    logic [31:0] d;
    rd(3'(c + 1), d);
    check(tag, d, lit);
    check({tag, " model"}, lit, exp_cnt[c]);
  endtask

  task automatic pulse_a0(int n);
    @(negedge clk);
    pa[0] = 1'b1;
    repeat (n) @(negedge clk);
    pa[0] = 1'b0;
    repeat (12) @(posedge clk);
  endtask

  logic done = 1'b0;

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, st;
    void'($urandom(32'd7177));
    for (int c = 0; c < NCH; c++) begin ctl[c] = '0; exp_cnt[c] = '0; end
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R11 reset state on every address
    for (int k = 0; k < 5; k++) begin
      rd(3'(k), d);
      check("R11 reset read", d, 32'd0);
    end

    // R2 quadrature forward, illegal, reverse on channel 0 (R1: reset control selects mode 0)
    tog(0, 0); tog(0, 1); tog(0, 0); tog(0, 1);
    cnt_is("R2 forward x4", 0, 32'd4);
    set_pins(pa | 4'b0001, pb | 4'b0001, pi);
    cnt_is("R2 illegal 00->11", 0, 32'd4);
    set_pins(pa & 4'b1110, pb & 4'b1110, pi);
    cnt_is("R2 illegal 11->00", 0, 32'd4);
    tog(0, 1);
    cnt_is("R2 reverse", 0, 32'd3);

    // R10 wrap below zero, writes to count ignored
    tog(1, 1);
    cnt_is("R10 wrap", 1, 32'hFFFF_FFFF);
    wr(3'd2, 32'h0000_1234);
    cnt_is("R10 write ignored", 1, 32'hFFFF_FFFF);

    // R3 direction modes on channel 2
    set_slice(2, 8'h01);
    tog(2, 1);
    tog(2, 0);
    cnt_is("R3 rise up", 2, 32'd1);
    tog(2, 0);
    cnt_is("R3 fall ignored in mode 1", 2, 32'd1);
    set_slice(2, 8'h02);
    tog(2, 0);
    tog(2, 0);
    cnt_is("R3 falling mode", 2, 32'd2);
    set_slice(2, 8'h03);
    tog(2, 1);
    tog(2, 0);
    cnt_is("R3 both down rise", 2, 32'd1);
    tog(2, 0);
    cnt_is("R3 both down fall", 2, 32'd0);

    // R4 gating by index level on channel 3
    set_slice(3, 8'h0D);
    tog(3, 1);
    tog(3, 0);
    cnt_is("R4 gated off idx low", 3, 32'd0);
    tog(3, 0);
    tog(3, 2);
    tog(3, 0);
    cnt_is("R4 gated on idx high", 3, 32'd1);
    set_slice(3, 8'h09);
    tog(3, 0); tog(3, 0);
    cnt_is("R4 low-only gate blocks", 3, 32'd1);

    // R6 edge clears on channel 3
    set_slice(3, 8'h41);
    tog(3, 0); tog(3, 0);
    cnt_is("R6 count before edge", 3, 32'd2);
    tog(3, 2);
    cnt_is("R6 falling idx no clear", 3, 32'd2);
    tog(3, 2);
    cnt_is("R6 rising idx clears", 3, 32'd0);
    rd(3'd0, st);
    check("R9 status idx3", st, 32'h0100_0000);
    tog(3, 0); tog(3, 0);
    set_slice(3, 8'h71);
    tog(3, 2); tog(3, 2);
    cnt_is("R6 code 7 no clear", 3, 32'd1);

    // R5 level clear on channel 1
    set_slice(1, 8'h30);
    tog(1, 0);
    cnt_is("R5 before level", 1, 32'hFFFF_FFFE);
    tog(1, 2);
    cnt_is("R5 idx high clears", 1, 32'd0);
    tog(1, 0);
    cnt_is("R5 held while high", 1, 32'd0);
    tog(1, 2);
    tog(1, 0);
    cnt_is("R5 released", 1, 32'hFFFF_FFFF);

    // R7 hold-at-zero beats a count step; R1 control write applies
    set_slice(0, 8'h11);
    cnt_is("R1 write applied", 0, 32'd0);
    tog(0, 0);
    cnt_is("R7 clear beats step", 0, 32'd0);
    tog(0, 0);

    // R8 filter drops 3-clock glitch, unfiltered 1-clock pulse counts
    set_slice(0, 8'h81);
    pulse_a0(3);
    cnt_is("R8 glitch filtered", 0, 32'd0);
    set_slice(0, 8'h01);
    pulse_a0(1);
    exp_cnt[0] = exp_cnt[0] + 1;
    cnt_is("R8 unfiltered pulse", 0, 32'd1);
    set_slice(0, 8'h81);
    pulse_a0(6);
    exp_cnt[0] = exp_cnt[0] + 1;
    cnt_is("R8 long pulse passes", 0, 32'd2);

    // random batches against the model
    for (int e = 0; e < 25; e++) begin
      wr(3'd0, $urandom);
      for (int s = 0; s < 12; s++) begin
        logic [3:0] na, nb, ni;
        na = pa; nb = pb; ni = pi;
        for (int c = 0; c < NCH; c++) begin
          int r;
          r = $urandom % 8;
          if (r < 3) na[c] = ~na[c];
          else if (r < 6) nb[c] = ~nb[c];
          else if (r == 6) ni[c] = ~ni[c];
        end
        set_pins(na, nb, ni);
      end
      for (int c = 0; c < NCH; c++) begin
        rd(3'(c + 1), d);
        check("R3 R5 R6 random count", d, exp_cnt[c]);
      end
      rd(3'd0, st);
      check("R9 random status", st, {7'd0, pi[3], 7'd0, pi[2], 7'd0, pi[1], 7'd0, pi[0]});
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule